// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register Block

This block is the control and status register file of one channel of an external DMA controller. Software reaches it through 32-bit register writes and reads. It holds the channel's transfer setup and hands that setup to a separate transfer engine as plain configuration signals. The setup covers the 64-bit source and destination addresses, each split into a lower and an upper word. It also covers a per-side width code and fixed-or-incrementing address mode, the byte count of one request, the number of requests, a request spacing count and a request source selector.

Software starts the engine by setting a run bit and requests an abort by clearing it. The engine reports progress back on three lines: a completion pulse, an error pulse and a level that shows a transfer is running. Completion and error are latched as raw interrupt flags, which software clears by writing ones. A masked view combines the raw flags with per-event enables, and one interrupt output is the OR of the masked flags. An abort is confirmed when the status register shows the busy level has dropped.

Top module: `xfer_chan_csr`

## Requirements
- R1: After reset every register reads 0, `eng_run` is 0 and `irq` is 0.
- R2: The configuration registers keep only their defined fields, and all other bits read 0.
  - Offset 0x08 keeps bits 23:16 and 5:0.
  - Offsets 0x10 and 0x14 keep bits 25:24 and bit 4.
  - Offsets 0x18, 0x1C, 0x20 and 0x24 keep all 32 bits.
  - Offset 0x28 keeps bits 25:0 and offset 0x2C keeps bits 15:0.
  - Offset 0x34 keeps bits 1:0.
- R3: The configuration outputs follow the registers.
  - `cfg_src_addr` is {0x18, 0x20} and `cfg_dst_addr` is {0x1C, 0x24}.
  - `cfg_src_width` is 0x10 bits 25:24 and `cfg_dst_width` is 0x14 bits 25:24.
  - `cfg_src_fixed` is 0x10 bit 4 and `cfg_dst_fixed` is 0x14 bit 4.
  - `cfg_req_bytes` is 0x28 bits 25:0 and `cfg_req_count` is 0x2C bits 15:0.
  - `cfg_gap` is 0x08 bits 23:16 and `cfg_req_sel` is 0x08 bits 5:0.
- R4: Writing 1 to bit 0 of offset 0x30 sets `eng_run` from the next cycle. Writing 0 clears it, which is the abort request. Offset 0x30 bit 0 reads back the run bit.
- R5: The run bit clears itself the cycle after `eng_done` or `eng_err`. A write to 0x30 in that same cycle takes precedence.
- R6: Bit 0 of offset 0x40 reads `eng_busy`, so it stays 1 after an abort request until the engine drops busy.
- R7: Offset 0x44 holds raw flags.
  - Bit 0 is set by `eng_done` and bit 1 by `eng_err`.
  - Writing 1 to a bit clears it.
  - Writing 0 to a bit leaves it unchanged.
- R8: An event in the same cycle as a write-1 clear of its bit leaves the bit set.
- R9: Offset 0x48 reads the raw flags ANDed with the enables at 0x34 (bit 0 for end, bit 1 for error). `irq` is the OR of those masked bits.
- R10: A read request returns data with `rd_valid` one cycle later. Offsets not listed here read 0, and writes to them change nothing. Writes to 0x40 and 0x48 change nothing either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 1 | Engine error pulse |
| eng_busy | input | 1 | Engine transfer in progress |
| cfg_src_addr | output | 64 | Source address |
| cfg_dst_addr | output | 64 | Destination address |
| cfg_src_fixed | output | 1 | Source address held fixed |
| cfg_dst_fixed | output | 1 | Destination address held fixed |
| cfg_src_width | output | 2 | Source width code, log2 of bytes |
| cfg_dst_width | output | 2 | Destination width code, log2 of bytes |
| cfg_req_bytes | output | 26 | Bytes per request |
| cfg_req_count | output | 16 | Number of requests |
| cfg_gap | output | 8 | Request interval count |
| cfg_req_sel | output | 6 | Request source selector |
| eng_run | output | 1 | Run bit to the engine |
| irq | output | 1 | Channel interrupt |

## Verification
A raw flag that is wrongly set or lost shows on `irq` in the cycle after the event once its enable is set. It also shows on the next read of 0x44 or 0x48, so clear-versus-event collisions are exercised with the enables both on and off. A run bit that fails to self-clear, or that loses against a simultaneous start write, is visible on `eng_run` one cycle after the engine pulse. A field mask or offset decode error appears at the configuration outputs in the cycle after the write, and in the read data one cycle after the read request.

// File: rtl/xcc_pkg.sv
package xcc_pkg;

  localparam int REG_W = 32;
  localparam int NCFG  = 10;
  localparam int NIRQ  = 2;

  // indices into the configuration bank
  localparam int IX_TFA  = 0;
  localparam int IX_SMOD = 1;
  localparam int IX_DMOD = 2;
  localparam int IX_SHI  = 3;
  localparam int IX_DHI  = 4;
  localparam int IX_SLO  = 5;
  localparam int IX_DLO  = 6;
  localparam int IX_BYTE = 7;
  localparam int IX_CNT  = 8;
  localparam int IX_IEN  = 9;

  localparam logic [7:0] OFF_START  = 8'h30;
  localparam logic [7:0] OFF_STATUS = 8'h40;
  localparam logic [7:0] OFF_RAW    = 8'h44;
  localparam logic [7:0] OFF_MASKED = 8'h48;

  function automatic logic [7:0] cfg_off(input int idx);
    case (idx)
      IX_TFA:  return 8'h08;
      IX_SMOD: return 8'h10;
      IX_DMOD: return 8'h14;
      IX_SHI:  return 8'h18;
      IX_DHI:  return 8'h1C;
      IX_SLO:  return 8'h20;
      IX_DLO:  return 8'h24;
      IX_BYTE: return 8'h28;
      IX_CNT:  return 8'h2C;
      default: return 8'h34;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] cfg_mask(input int idx);
    case (idx)
      IX_TFA:           return 32'h00FF_003F;
      IX_SMOD, IX_DMOD: return 32'h0300_0010;
      IX_BYTE:          return 32'h03FF_FFFF;
      IX_CNT:           return 32'h0000_FFFF;
      IX_IEN:           return 32'h0000_0003;
      default:          return 32'hFFFF_FFFF;
    endcase
  endfunction

  // one raw flag: a new event beats a simultaneous clear
  function automatic logic flag_next(input logic cur, input logic ev, input logic clr);
    return ev | (cur & ~clr);
  endfunction

endpackage

// File: rtl/xcc_cfg_bank.sv
module xcc_cfg_bank
  import xcc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [REG_W-1:0]        wr_data,
  output logic [NCFG*REG_W-1:0]   cfg_flat
);

  for (genvar g = 0; g < NCFG; g++) begin : g_reg
    localparam logic [REG_W-1:0] MASK = cfg_mask(g);
    logic              hit;
    logic [REG_W-1:0]  word_q;

    assign hit = wr_en && (wr_addr == ADDR_W'(cfg_off(g)));

    always_ff @(posedge clk) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wr_data & MASK;
    end

    assign cfg_flat[g*REG_W +: REG_W] = word_q;
  end

endmodule

// File: rtl/xcc_run_ctl.sv
module xcc_run_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_wr,
  input  logic start_bit,
  input  logic eng_done,
  input  logic eng_err,
  output logic run_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)                  run_q <= 1'b0;
    else if (start_wr)           run_q <= start_bit;
    else if (eng_done || eng_err) run_q <= 1'b0;
  end

endmodule

// File: rtl/xcc_irq_ctl.sv
module xcc_irq_ctl
  import xcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_wr,
  input  logic [NIRQ-1:0] clr_bits,
  input  logic [NIRQ-1:0] ev,
  input  logic [NIRQ-1:0] ien,
  output logic [NIRQ-1:0] raw_q,
  output logic [NIRQ-1:0] masked,
  output logic            irq
);

  for (genvar b = 0; b < NIRQ; b++) begin : g_flag
    logic clr_this;
    assign clr_this = clr_wr & clr_bits[b];

    always_ff @(posedge clk) begin
      if (!rst_n) raw_q[b] <= 1'b0;
      else        raw_q[b] <= flag_next(raw_q[b], ev[b], clr_this);
    end

    assign masked[b] = raw_q[b] & ien[b];
  end

  assign irq = |masked;

endmodule

// File: rtl/xcc_rd_port.sv
module xcc_rd_port
  import xcc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [NCFG*REG_W-1:0] cfg_flat,
  input  logic                  run_q,
  input  logic                  busy,
  input  logic [NIRQ-1:0]       raw_q,
  input  logic [NIRQ-1:0]       masked,
  output logic [REG_W-1:0]      rd_data,
  output logic                  rd_valid
);

  logic [REG_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NCFG; i++) begin
      if (rd_addr == ADDR_W'(cfg_off(i))) sel = cfg_flat[i*REG_W +: REG_W];
    end
    if (rd_addr == ADDR_W'(OFF_START))  sel = {{(REG_W-1){1'b0}}, run_q};
    if (rd_addr == ADDR_W'(OFF_STATUS)) sel = {{(REG_W-1){1'b0}}, busy};
    if (rd_addr == ADDR_W'(OFF_RAW))    sel = {{(REG_W-NIRQ){1'b0}}, raw_q};
    if (rd_addr == ADDR_W'(OFF_MASKED)) sel = {{(REG_W-NIRQ){1'b0}}, masked};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel;
    end
  end

endmodule

// File: rtl/xfer_chan_csr.sv
module xfer_chan_csr
  import xcc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_busy,
  output logic [63:0]       cfg_src_addr,
  output logic [63:0]       cfg_dst_addr,
  output logic              cfg_src_fixed,
  output logic              cfg_dst_fixed,
  output logic [1:0]        cfg_src_width,
  output logic [1:0]        cfg_dst_width,
  output logic [25:0]       cfg_req_bytes,
  output logic [15:0]       cfg_req_count,
  output logic [7:0]        cfg_gap,
  output logic [5:0]        cfg_req_sel,
  output logic              eng_run,
  output logic              irq
);

  logic [NCFG*REG_W-1:0] cfg_flat;
  logic [REG_W-1:0]      w_tfa, w_smod, w_dmod, w_ien;

  // named internal events, shared with the checker
  logic                  start_wr;
  logic                  clr_wr;
  logic [NIRQ-1:0]       raw_q;
  logic [NIRQ-1:0]       masked;
  logic [NIRQ-1:0]       ien_bits;

  assign start_wr = wr_en && (wr_addr == ADDR_W'(OFF_START));
  assign clr_wr   = wr_en && (wr_addr == ADDR_W'(OFF_RAW));

  xcc_cfg_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_flat(cfg_flat)
  );

  assign w_tfa  = cfg_flat[IX_TFA*REG_W  +: REG_W];
  assign w_smod = cfg_flat[IX_SMOD*REG_W +: REG_W];
  assign w_dmod = cfg_flat[IX_DMOD*REG_W +: REG_W];
  assign w_ien  = cfg_flat[IX_IEN*REG_W  +: REG_W];

  assign cfg_src_addr  = {cfg_flat[IX_SHI*REG_W +: REG_W], cfg_flat[IX_SLO*REG_W +: REG_W]};
  assign cfg_dst_addr  = {cfg_flat[IX_DHI*REG_W +: REG_W], cfg_flat[IX_DLO*REG_W +: REG_W]};
  assign cfg_src_width = w_smod[25:24];
  assign cfg_dst_width = w_dmod[25:24];
  assign cfg_src_fixed = w_smod[4];
  assign cfg_dst_fixed = w_dmod[4];
  assign cfg_req_bytes = cfg_flat[IX_BYTE*REG_W +: 26];
  assign cfg_req_count = cfg_flat[IX_CNT*REG_W  +: 16];
  assign cfg_gap       = w_tfa[23:16];
  assign cfg_req_sel   = w_tfa[5:0];
  assign ien_bits      = w_ien[NIRQ-1:0];

  xcc_run_ctl u_run (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_bit(wr_data[0]),
    .eng_done(eng_done), .eng_err(eng_err), .run_q(eng_run)
  );

  xcc_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .clr_bits(wr_data[NIRQ-1:0]),
    .ev({eng_err, eng_done}), .ien(ien_bits), .raw_q(raw_q),
    .masked(masked), .irq(irq)
  );

  xcc_rd_port #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .cfg_flat(cfg_flat), .run_q(eng_run), .busy(eng_busy),
    .raw_q(raw_q), .masked(masked), .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: rtl/xcc_checker.sv
module xcc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start_wr,
  input logic       clr_wr,
  input logic [1:0] wr_bits,
  input logic       rd_en,
  input logic       rd_valid,
  input logic       eng_done,
  input logic       eng_err,
  input logic [1:0] raw,
  input logic [1:0] ien,
  input logic       run,
  input logic       irq
);

  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> raw[0]);

  assert_err_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> raw[1]);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wr_bits[0] && !eng_done) |=> !raw[0]);

  assert_keep_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !wr_bits[1] && raw[1]) |=> raw[1]);

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && wr_bits[1] && eng_err) |=> raw[1]);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq);

  assert_irq_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_err && ien[1]) |=> irq);

  assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && wr_bits[0]) |=> run);

  assert_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((eng_done || eng_err) && !start_wr) |=> !run);

  assert_read_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_no_spurious_rd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

endmodule

bind xfer_chan_csr xcc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .clr_wr(clr_wr),
  .wr_bits(wr_data[1:0]), .rd_en(rd_en), .rd_valid(rd_valid),
  .eng_done(eng_done), .eng_err(eng_err), .raw(raw_q), .ien(ien_bits),
  .run(eng_run), .irq(irq)
);

// File: tb/test_xfer_chan_csr.sv
`timescale 1ns/1ps
module test_xfer_chan_csr;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        eng_done = 1'b0, eng_err = 1'b0, eng_busy = 1'b0;
  logic [63:0] cfg_src_addr, cfg_dst_addr;
  logic        cfg_src_fixed, cfg_dst_fixed;
  logic [1:0]  cfg_src_width, cfg_dst_width;
  logic [25:0] cfg_req_bytes;
  logic [15:0] cfg_req_count;
  logic [7:0]  cfg_gap;
  logic [5:0]  cfg_req_sel;
  logic        eng_run, irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  xfer_chan_csr i_xfer_chan_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .eng_done(eng_done), .eng_err(eng_err), .eng_busy(eng_busy),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_fixed(cfg_src_fixed), .cfg_dst_fixed(cfg_dst_fixed),
    .cfg_src_width(cfg_src_width), .cfg_dst_width(cfg_dst_width),
    .cfg_req_bytes(cfg_req_bytes), .cfg_req_count(cfg_req_count),
    .cfg_gap(cfg_gap), .cfg_req_sel(cfg_req_sel), .eng_run(eng_run), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read values as the design returns them
  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check("R10 unexpected rd_valid", 64'(rd_data), 64'hDEAD);
      else check(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
    end
  end

  // all tasks start and end at a falling edge
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_ev(input logic [7:0] a, input logic [31:0] d, input logic dn, input logic er);
    wr_en = 1'b1; wr_addr = a; wr_data = d; eng_done = dn; eng_err = er;
    @(negedge clk);
    wr_en = 1'b0; eng_done = 1'b0; eng_err = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_ev(a, d, 1'b0, 1'b0);
  endtask

  task automatic pulse(input logic dn, input logic er);
    eng_done = dn; eng_err = er;
    @(negedge clk);
    eng_done = 1'b0; eng_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 run", 64'(eng_run), 64'd0);
    rd(8'h08, 32'h0, "R1 tfa");
    rd(8'h20, 32'h0, "R1 src lo");
    rd(8'h44, 32'h0, "R1 raw");
    rd(8'h34, 32'h0, "R1 ien");

    // R2 field masks
    for (int i = 0; i < 10; i++) begin
      logic [7:0] offs [10] = '{8'h08,8'h10,8'h14,8'h18,8'h1C,8'h20,8'h24,8'h28,8'h2C,8'h34};
      wr(offs[i], 32'hFFFF_FFFF);
    end
    rd(8'h08, 32'h00FF_003F, "R2 tfa mask");
    rd(8'h10, 32'h0300_0010, "R2 src mode mask");
    rd(8'h14, 32'h0300_0010, "R2 dst mode mask");
    rd(8'h18, 32'hFFFF_FFFF, "R2 src hi");
    rd(8'h24, 32'hFFFF_FFFF, "R2 dst lo");
    rd(8'h28, 32'h03FF_FFFF, "R2 bytes mask");
    rd(8'h2C, 32'h0000_FFFF, "R2 count mask");
    rd(8'h34, 32'h0000_0003, "R2 ien mask");
    wr(8'h34, 32'h0);

    // R3 configuration outputs
    wr(8'h20, 32'h1234_5678); wr(8'h18, 32'h0000_00AB);
    wr(8'h24, 32'h9ABC_DEF0); wr(8'h1C, 32'h0000_0C0D);
    wr(8'h10, 32'h0200_0010); wr(8'h14, 32'h0100_0000);
    wr(8'h08, 32'h0014_0005); wr(8'h28, 32'h0400_0010); wr(8'h2C, 32'h0001_0003);
    check("R3 src addr", cfg_src_addr, 64'h0000_00AB_1234_5678);
    check("R3 dst addr", cfg_dst_addr, 64'h0000_0C0D_9ABC_DEF0);
    check("R3 src width", 64'(cfg_src_width), 64'd2);
    check("R3 src fixed", 64'(cfg_src_fixed), 64'd1);
    check("R3 dst width", 64'(cfg_dst_width), 64'd1);
    check("R3 dst fixed", 64'(cfg_dst_fixed), 64'd0);
    check("R3 gap", 64'(cfg_gap), 64'h14);
    check("R3 req sel", 64'(cfg_req_sel), 64'd5);
    check("R3 req bytes", 64'(cfg_req_bytes), 64'h10);
    check("R3 req count", 64'(cfg_req_count), 64'd3);

    // R10 unmapped and read-only offsets
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h21, 32'hFFFF_FFFF);
    wr(8'h48, 32'hFFFF_FFFF);
    rd(8'h0C, 32'h0, "R10 unmapped read");
    rd(8'h20, 32'h1234_5678, "R10 neighbour untouched");
    rd(8'h48, 32'h0, "R10 masked not writable");
    check("R10 src addr intact", cfg_src_addr, 64'h0000_00AB_1234_5678);

    // R4 start and abort, R6 busy
    wr(8'h30, 32'h1);
    check("R4 run set", 64'(eng_run), 64'd1);
    rd(8'h30, 32'h1, "R4 start readback");
    eng_busy = 1'b1;
    rd(8'h40, 32'h1, "R6 busy");
    wr(8'h30, 32'h0);
    check("R4 abort clears run", 64'(eng_run), 64'd0);
    rd(8'h40, 32'h1, "R6 busy until engine stops");
    eng_busy = 1'b0;
    rd(8'h40, 32'h0, "R6 abort confirmed");

    // R5 self clear on done
    wr(8'h30, 32'h1);
    pulse(1'b1, 1'b0);
    check("R5 self clear on done", 64'(eng_run), 64'd0);
    rd(8'h44, 32'h1, "R7 done sets raw0");
    rd(8'h48, 32'h0, "R9 masked with no enable");
    check("R9 irq off without enable", 64'(irq), 64'd0);

    // R9 enables and irq
    wr(8'h34, 32'h3);
    check("R9 irq on end enable", 64'(irq), 64'd1);
    rd(8'h48, 32'h1, "R9 masked end");
    pulse(1'b0, 1'b1);
    rd(8'h44, 32'h3, "R7 err sets raw1");
    rd(8'h48, 32'h3, "R9 masked both");

    // R7 write-0 keeps, write-1 clears
    wr(8'h44, 32'h0);
    rd(8'h44, 32'h3, "R7 write zero keeps");
    wr(8'h44, 32'h2);
    rd(8'h44, 32'h1, "R7 write one clears err only");
    check("R9 irq from end", 64'(irq), 64'd1);
    wr(8'h34, 32'h2);
    check("R9 irq gated by enable", 64'(irq), 64'd0);
    rd(8'h48, 32'h0, "R9 masked gated");
    wr(8'h44, 32'h1);
    rd(8'h44, 32'h0, "R7 raw cleared");

    // R8 event and clear in one cycle
    wr_ev(8'h44, 32'h1, 1'b1, 1'b0);
    rd(8'h44, 32'h1, "R8 done survives clear");
    wr_ev(8'h44, 32'h3, 1'b0, 1'b1);
    rd(8'h44, 32'h2, "R8 err survives clear, done cleared");
    check("R8 irq from err", 64'(irq), 64'd1);
    wr(8'h44, 32'h3);
    rd(8'h44, 32'h0, "R8 cleared afterwards");

    // R5 start write beats error in the same cycle
    wr_ev(8'h30, 32'h1, 1'b0, 1'b1);
    check("R5 start write wins", 64'(eng_run), 64'd1);
    pulse(1'b0, 1'b1);
    check("R5 self clear on error", 64'(eng_run), 64'd0);

    repeat (3) @(negedge clk);
    check("R10 all reads returned", 64'(exp_q.size()), 64'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule